// File: doc/BRIEF.md
# Halt and Wake Sequencer

This block moves a small microcontroller between normal execution and two halted states. A strobe from the CPU asks it to halt. A control bit, sampled with that strobe, chooses whether the main oscillator is switched off (deep halt) or left running (oscillator-on halt). When the CPU halts, the block forces the interrupt mask clear so that a later interrupt can wake the part. If the part halts with the oscillator off while the watchdog is armed, the block requests a reset and does not halt.

A reset request, or an interrupt on a line that is allowed to end a halt, wakes the part. The oscillator enable rises in the cycle the wake is detected. The block then holds the CPU clock gate closed for a fixed number of CPU cycles. After that it reopens the gate and reports whether the CPU should service an interrupt, and which one, or fetch the reset vector. The block also makes the CPU clock enable, which divides the main clock by two.

Top module: `halt_ctl`

## Requirements
- R1: After `rst_n` is released the block is running: `cpu_gate`=1, `osc_en`=1, `wake_valid`=0 and `wdg_rst`=0. `cpu_ce` alternates between 1 and 0 on every main clock edge, which gives one CPU cycle for every two main clock cycles.
- R2: A `halt_req` sampled while running and while `cpu_ce`=1 halts the CPU, and `cpu_gate` falls to 0. With `oie`=0 `osc_en` falls to 0 (deep halt). With `oie`=1 `osc_en` stays at 1 (oscillator-on halt). `cpu_gate` is never 1 while `osc_en` is 0.
- R3: Entry into either halt state gives a `imask_clr` pulse that is exactly one main clock cycle long, in the first cycle of the halt. The watchdog path of R4 gives no such pulse.
- R4: A `halt_req` with `oie`=0 and `wdg_en`=1 does not halt. Instead it gives a one-cycle `wdg_rst` pulse, keeps `osc_en` at 1, and starts the start-up delay with the reset-vector cause. With `oie`=1 and `wdg_en`=1 the halt takes place and there is no `wdg_rst`.
- R5: While halted, only `irq` lines whose bit is set in `WAKE_MASK` can wake the part. An active line whose mask bit is 0 leaves `osc_en` and `cpu_gate` unchanged.
- R6: In deep halt, `osc_en` returns to 1 combinationally in the same cycle that a wake interrupt is sampled (`cpu_ce`=1) or `ext_rst` is asserted.
- R7: After a wake, `cpu_gate` stays 0 for exactly `DELAY` pulses of `cpu_ce` (4096 by default), counted from the cycle after the wake edge. It then rises, and `wake_valid` pulses for one cycle as it rises.
- R8: At resume, `wake_irq`=1 means "service an interrupt". In that case `wake_idx` is the lowest-numbered active wake-capable line at the moment the wake was sampled. `wake_irq`=0 means "fetch the reset vector".
- R9: An `ext_rst` during the start-up delay starts the `DELAY` count again from zero and changes a pending interrupt cause to the reset cause.
- R10: A `halt_req` that arrives while halted or during the start-up delay has no effect.
- R11: An `ext_rst` asserted while running or halted starts the start-up delay with the reset cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Asynchronous active-low initialisation of the controller |
| halt_req | input | 1 | Halt-instruction strobe from the CPU |
| oie | input | 1 | Halt kind: 0 selects deep halt, 1 selects oscillator-on halt |
| wdg_en | input | 1 | Watchdog armed |
| ext_rst | input | 1 | Reset request, which is also a wake event |
| irq | input | NIRQ | Level interrupt requests |
| osc_en | output | 1 | Main oscillator enable |
| cpu_ce | output | 1 | Divide-by-two CPU clock enable |
| cpu_gate | output | 1 | CPU clock gate: 1 lets the CPU run |
| imask_clr | output | 1 | Pulse that forces the interrupt mask bit to 0 |
| wdg_rst | output | 1 | Watchdog reset request pulse |
| wake_valid | output | 1 | One-cycle pulse when the CPU resumes |
| wake_irq | output | 1 | Wake cause: 1 means interrupt, 0 means reset vector |
| wake_idx | output | IW | Index of the interrupt that woke the part |

## Verification
On every cycle the assertions check the local invariants: the strict alternation of `cpu_ce`, a closed clock gate whenever the oscillator is off, single-cycle mask-clear pulses, the oscillator state while a watchdog reset is raised, a gate that opens only together with `wake_valid`, and a reported wake index that always names a line allowed to wake. Only the directed scenarios can show the exact length of the start-up delay and its restart by a reset. The same holds for the lowest-index choice among several active lines, and for the interrupts and strobes that must be ignored.

// File: rtl/halt_ctl.sv
module halt_ctl #(
  parameter int NIRQ = 4,
  parameter logic [NIRQ-1:0] WAKE_MASK = '1,
  parameter int DELAY = 4096,
  parameter int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt_req,
  input  logic            oie,
  input  logic            wdg_en,
  input  logic            ext_rst,
  input  logic [NIRQ-1:0] irq,
  output logic            osc_en,
  output logic            cpu_ce,
  output logic            cpu_gate,
  output logic            imask_clr,
  output logic            wdg_rst,
  output logic            wake_valid,
  output logic            wake_irq,
  output logic [IW-1:0]   wake_idx
);
  localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;

  typedef enum logic [1:0] {S_RUN, S_HALT, S_AHALT, S_DLY} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [NIRQ-1:0] hit;
  logic [IW-1:0]  pick;
  logic           halted, wake_now, take_halt, wdg_trip;

  assign hit       = irq & WAKE_MASK;
  assign halted    = (st == S_HALT) || (st == S_AHALT);
  assign wake_now  = halted && cpu_ce && (|hit);
  assign take_halt = (st == S_RUN) && cpu_ce && halt_req;
  assign wdg_trip  = take_halt && !oie && wdg_en;
  assign osc_en    = (st != S_HALT) || wake_now || ext_rst;
  assign cpu_gate  = (st == S_RUN);

  always_comb begin
    pick = '0;
    for (int i = NIRQ - 1; i >= 0; i--)
      if (hit[i]) pick = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_RUN;
      cnt        <= '0;
      cpu_ce     <= 1'b0;
      imask_clr  <= 1'b0;
      wdg_rst    <= 1'b0;
      wake_valid <= 1'b0;
      wake_irq   <= 1'b0;
      wake_idx   <= '0;
    end else begin
      cpu_ce     <= ~cpu_ce;
      imask_clr  <= 1'b0;
      wdg_rst    <= 1'b0;
      wake_valid <= 1'b0;
      if (ext_rst) begin
        st       <= S_DLY;
        cnt      <= '0;
        wake_irq <= 1'b0;
        wake_idx <= '0;
      end else begin
        case (st)
          S_RUN: if (take_halt) begin
            if (wdg_trip) begin
              st       <= S_DLY;
              cnt      <= '0;
              wake_irq <= 1'b0;
              wake_idx <= '0;
              wdg_rst  <= 1'b1;
            end else begin
              st        <= oie ? S_AHALT : S_HALT;
              imask_clr <= 1'b1;
            end
          end
          S_HALT, S_AHALT: if (wake_now) begin
            st       <= S_DLY;
            cnt      <= '0;
            wake_irq <= 1'b1;
            wake_idx <= pick;
          end
          S_DLY: if (cpu_ce) begin
            if (cnt == CW'(DELAY - 1)) begin
              st         <= S_RUN;
              wake_valid <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= S_RUN;
        endcase
      end
    end
  end
endmodule

// File: rtl/halt_ctl_chk.sv
module halt_ctl_chk #(
  parameter int NIRQ = 4,
  parameter logic [NIRQ-1:0] WAKE_MASK = '1,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_ce,
  input logic          cpu_gate,
  input logic          osc_en,
  input logic          imask_clr,
  input logic          wdg_rst,
  input logic          wake_valid,
  input logic          wake_irq,
  input logic [IW-1:0] wake_idx
);
  // R1
  ce_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) cpu_ce |=> !cpu_ce);
  // R1
  ce_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) !cpu_ce |=> cpu_ce);
  // R2
  gate_osc_chk: assert property (@(posedge clk) disable iff (!rst_n) !osc_en |-> !cpu_gate);
  // R3
  mask_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) imask_clr |=> !imask_clr);
  // R3
  mask_halt_chk: assert property (@(posedge clk) disable iff (!rst_n) imask_clr |-> !cpu_gate && !wdg_rst);
  // R4
  wdg_osc_chk: assert property (@(posedge clk) disable iff (!rst_n) wdg_rst |-> osc_en && !cpu_gate);
  // R7
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(cpu_gate) |-> wake_valid);
  // R8
  cause_chk: assert property (@(posedge clk) disable iff (!rst_n) wake_valid && wake_irq |-> WAKE_MASK[wake_idx]);
endmodule

bind halt_ctl halt_ctl_chk #(.NIRQ(NIRQ), .WAKE_MASK(WAKE_MASK), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .cpu_gate(cpu_gate), .osc_en(osc_en),
  .imask_clr(imask_clr), .wdg_rst(wdg_rst), .wake_valid(wake_valid),
  .wake_irq(wake_irq), .wake_idx(wake_idx)
);

// File: tb/sim_halt_ctl.sv
module sim_halt_ctl;
  localparam int NIRQ = 4;
  localparam int DELAY = 4096;
  localparam logic [3:0] MASK = 4'b1101;

  logic clk = 0, rst_n = 0, halt_req = 0, oie = 0, wdg_en = 0, ext_rst = 0;
  logic [NIRQ-1:0] irq = '0;
  logic osc_en, cpu_ce, cpu_gate, imask_clr, wdg_rst, wake_valid, wake_irq;
  logic [1:0] wake_idx;
  int total = 0, bad = 0;
  bit saw_wdg, saw_mask, saw_osc_off, saw_gate, vld_at_rise;

  always #5 clk = ~clk;

  halt_ctl #(.NIRQ(NIRQ), .WAKE_MASK(MASK), .DELAY(DELAY)) u0 (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .oie(oie), .wdg_en(wdg_en),
    .ext_rst(ext_rst), .irq(irq), .osc_en(osc_en), .cpu_ce(cpu_ce), .cpu_gate(cpu_gate),
    .imask_clr(imask_clr), .wdg_rst(wdg_rst), .wake_valid(wake_valid),
    .wake_irq(wake_irq), .wake_idx(wake_idx));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic at_ce();
    do @(negedge clk); while (!cpu_ce);
  endtask

  task automatic wait_resume(output int n);
    n = 0; saw_wdg = 0; saw_mask = 0; saw_osc_off = 0; vld_at_rise = 0;
    forever begin
      @(negedge clk);
      ext_rst = 0;
      if (wdg_rst) saw_wdg = 1;
      if (imask_clr) saw_mask = 1;
      if (!osc_en) saw_osc_off = 1;
      if (cpu_gate) begin vld_at_rise = wake_valid; break; end
      if (cpu_ce) n++;
    end
    @(negedge clk);
    chk("R7 wake_valid single cycle", wake_valid, 0);
  endtask

  task automatic go_halt(logic k);
    at_ce();
    oie = k; halt_req = 1;
    @(negedge clk);
    halt_req = 0;
    chk("R2 gate closed", cpu_gate, 0);
    chk("R2 osc per oie", osc_en, k);
    chk("R3 mask pulse", imask_clr, 1);
    @(negedge clk);
    chk("R3 mask pulse ends", imask_clr, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 gate", cpu_gate, 1);
    chk("R1 osc", osc_en, 1);
    chk("R1 valid", wake_valid, 0);
    chk("R1 wdg", wdg_rst, 0);
    for (int i = 0; i < 4; i++) begin
      logic p = cpu_ce;
      @(negedge clk);
      chk("R1 ce toggles", cpu_ce, !p);
    end
  endtask

  task automatic t_deep_irq();
    int n;
    bit moved = 0;
    wdg_en = 0;
    go_halt(0);
    irq = 4'b0010;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (osc_en || cpu_gate) moved = 1;
    end
    chk("R5 masked line ignored", moved, 0);
    irq = 0;
    at_ce(); halt_req = 1; @(negedge clk); halt_req = 0;
    @(negedge clk);
    chk("R10 halt while halted: osc", osc_en, 0);
    chk("R10 halt while halted: mask", imask_clr, 0);
    at_ce();
    irq = 4'b1100;
    #1;
    chk("R6 osc same cycle", osc_en, 1);
    wait_resume(n);
    irq = 0;
    chk("R7 delay length", n, DELAY);
    chk("R7 valid at rise", vld_at_rise, 1);
    chk("R8 irq cause", wake_irq, 1);
    chk("R8 lowest index", wake_idx, 2);
  endtask

  task automatic t_active_halt();
    int n;
    wdg_en = 1;
    go_halt(1);
    chk("R4 no wdg reset in oscillator-on halt", wdg_rst, 0);
    at_ce();
    irq = 4'b1001;
    wait_resume(n);
    irq = 0;
    chk("R4 no wdg reset during wake", saw_wdg, 0);
    chk("R7 delay length", n, DELAY);
    chk("R8 lowest index", wake_idx, 0);
    chk("R8 irq cause", wake_irq, 1);
    wdg_en = 0;
  endtask

  task automatic t_wdg();
    int n;
    wdg_en = 1; oie = 0;
    at_ce();
    halt_req = 1;
    wait_resume(n);
    halt_req = 0;
    chk("R4 wdg reset pulse", saw_wdg, 1);
    chk("R4 osc kept on", saw_osc_off, 0);
    chk("R3 no mask pulse on wdg path", saw_mask, 0);
    chk("R4 delay length", n, DELAY);
    chk("R4 reset cause", wake_irq, 0);
    wdg_en = 0;
  endtask

  task automatic t_restart();
    int n;
    bit opened = 0;
    go_halt(0);
    at_ce();
    irq = 4'b1000;
    @(negedge clk);
    irq = 0;
    for (int i = 0; i < 2000; i++) begin
      if (i == 500 && cpu_ce) halt_req = 1;
      if (i == 502) halt_req = 0;
      @(negedge clk);
      if (cpu_gate || imask_clr) opened = 1;
    end
    halt_req = 0;
    chk("R10 halt during delay ignored", opened, 0);
    ext_rst = 1;
    wait_resume(n);
    chk("R9 count restarted", n, DELAY);
    chk("R9 reset overrides cause", wake_irq, 0);
  endtask

  task automatic t_rst_halt();
    int n;
    go_halt(0);
    ext_rst = 1;
    #1;
    chk("R6 osc on reset wake", osc_en, 1);
    wait_resume(n);
    chk("R11 delay from halt", n, DELAY);
    chk("R11 reset cause", wake_irq, 0);
    ext_rst = 1;
    wait_resume(n);
    chk("R11 delay from run", n, DELAY);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_deep_irq();
    t_active_halt();
    t_wdg();
    t_restart();
    t_rst_halt();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R7 actual=hung expected=resume");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule